// File: doc/BRIEF.md
# Backscatter Receive Sequencer

This block sequences the receive side of a tag-reading baseband. After an enable it waits for the demodulator to report a valid incoming signal. It then waits for the first symbol timing to be locked. Next it searches the decoded symbol stream for the start-of-frame pattern of the selected line code. When that pattern is seen, it holds a frame-active window until the payload is complete. It then parks in an end state until the enable is withdrawn.

Correlation, timing recovery and symbol decoding sit outside this block. Their results arrive here as single-cycle strobes and as a symbol stream. Each symbol carries a bit, a valid qualifier and a code-violation flag. Withdrawing the enable from any busy state returns the machine to idle and pulses a clear strobe toward the datapath.

Top module: `bsrx_ctrl`

## Requirements
- R1: After reset, stateCode is 0 (idle) and sfdFound, frameActive and dpClear are all low.
- R2: State codes are idle=0, sensing=1, timing=2, frame search=3, payload=4, end=5. From idle the machine moves to sensing one cycle after rxEn is high, and stays idle while rxEn is low.
- R3: Sensing advances to timing on rxEn with sigDetect. Timing advances to frame search on rxEn with timingDone. Each step is taken at the next clock edge.
- R4: With lineCode=0 (FM0), the symbol sequence 1,0,1,0,X,1 moves frame search to payload, where X is any bit with symViol=1 and the other five symbols carry symViol=0. sfdFound is high for exactly the one cycle in which the payload state is first shown.
- R5: With lineCode=0, the sequence 1,0,1,0,0,1 with no violation flag does not end the frame search.
- R6: With lineCode=1 (Miller), the seven symbols 0,1,0,1,1,1,1, all without violation, move frame search to payload. Leading symbols that are not part of the pattern do not prevent the match.
- R7: A symbol presented with symValid=0 is ignored by the pattern search.
- R8: Payload advances to end on rxEn with rxDone. frameActive is high exactly while stateCode is 4.
- R9: The end state holds while rxEn stays high, whatever the sigDetect, timingDone and rxDone strobes do.
- R10: In any non-idle state, rxEn low returns the machine to idle at the next edge. dpClear then pulses high for exactly one cycle.
- R11: The pattern search starts empty on each entry to frame search. Symbols taken before an abort never complete a match after re-entry.
- R12: Strobes other than the one for the current state have no effect. An abort takes priority over an advance strobe arriving in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxEn | input | 1 | Receive enable; low aborts to idle |
| sigDetect | input | 1 | Valid incoming signal found |
| timingDone | input | 1 | First symbol timing locked |
| rxDone | input | 1 | Payload reception finished |
| lineCode | input | 1 | 0 = FM0, 1 = Miller |
| symBit | input | 1 | Decoded symbol value |
| symValid | input | 1 | Symbol qualifier |
| symViol | input | 1 | Code-violation flag of the symbol |
| stateCode | output | 3 | Current state, binary |
| sfdFound | output | 1 | One-cycle pulse on start-of-frame match |
| frameActive | output | 1 | High while receiving payload |
| dpClear | output | 1 | One-cycle clear pulse on entry to idle |

## Verification
The bench builds the block with its default parameters. These are a six-symbol FM0 pattern with the violation in the fifth slot, a seven-symbol Miller pattern, and hence a seven-deep search window. With these values both line codes are tested. The tests include the FM0 pattern without its violation, a Miller match preceded by noise symbols, and the case of a partial prefix left over from an aborted search. The bench also covers an abort from each of the five non-idle states and holds in the end state under stray strobes.

// File: rtl/bsrx_pkg.sv
package bsrx_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE   = 3'd0,
    ST_SENSE  = 3'd1,
    ST_TIMING = 3'd2,
    ST_SFD    = 3'd3,
    ST_DATA   = 3'd4,
    ST_END    = 3'd5
  } rxState_e;

  // strobes from control to the pattern datapath
  typedef struct packed {
    logic clrMatch;
    logic shiftEn;
  } ctlStrobe_t;

  localparam int LC_FM0    = 0;
  localparam int LC_MILLER = 1;
endpackage

// File: rtl/bsrx_sfd_match.sv
module bsrx_sfd_match
  import bsrx_pkg::*;
#(
  parameter int FM0_LEN = 6,
  parameter int MIL_LEN = 7,
  parameter logic [FM0_LEN-1:0] FM0_PAT   = 6'b101001,
  parameter logic [FM0_LEN-1:0] FM0_VMASK = 6'b000010,
  parameter logic [MIL_LEN-1:0] MIL_PAT   = 7'b0101111
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strb,
  input  logic       lineCode,
  input  logic       symBit,
  input  logic       symViol,
  output logic       sfdHit
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int WIN = (FM0_LEN > MIL_LEN) ? FM0_LEN : MIL_LEN;
  localparam int CW  = $clog2(WIN + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(WIN);
  localparam logic [CW-1:0] FM0_NEED = CW'(FM0_LEN - 1);
  localparam logic [CW-1:0] MIL_NEED = CW'(MIL_LEN - 1);

  logic [WIN-1:0] bitSh, violSh;
  logic [WIN-1:0] winBits, winViol;
  logic [CW-1:0]  symCnt;
  logic           fm0Hit, milHit;

  // window including the symbol on the inputs now (newest in bit 0)
  assign winBits = {bitSh[WIN-2:0], symBit};
  assign winViol = {violSh[WIN-2:0], symViol};

  // one shift stage per window slot
  for (genvar g = 0; g < WIN; g++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bitSh[g]  <= 1'b0;
        violSh[g] <= 1'b0;
      end else if (strb.clrMatch) begin
        bitSh[g]  <= 1'b0;
        violSh[g] <= 1'b0;
      end else if (strb.shiftEn) begin
        bitSh[g]  <= winBits[g];
        violSh[g] <= winViol[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      symCnt <= '0;
    else if (strb.clrMatch)
      symCnt <= '0;
    else if (strb.shiftEn && symCnt != CNT_MAX)
      symCnt <= symCnt + 1'b1;
  end

  always_comb begin
    fm0Hit = (symCnt >= FM0_NEED)
          && ((winBits[FM0_LEN-1:0] & ~FM0_VMASK) == (FM0_PAT & ~FM0_VMASK))
          && (winViol[FM0_LEN-1:0] == FM0_VMASK);
    milHit = (symCnt >= MIL_NEED)
          && (winBits[MIL_LEN-1:0] == MIL_PAT)
          && (winViol[MIL_LEN-1:0] == '0);
    sfdHit = strb.shiftEn && ((lineCode == 1'(LC_MILLER)) ? milHit : fm0Hit);
  end
endmodule

// File: rtl/bsrx_fsm.sv
module bsrx_fsm
  import bsrx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEn,
  input  logic       sigDetect,
  input  logic       timingDone,
  input  logic       rxDone,
  input  logic       symValid,
  input  logic       sfdHit,
  output rxState_e   state,
  output ctlStrobe_t strb,
  output logic       sfdFound,
  output logic       dpClear
);
  timeunit 1ns;
  timeprecision 1ps;

  rxState_e nextState;

  always_comb begin
    nextState = state;
    if (!rxEn) begin
      nextState = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:   nextState = ST_SENSE;
        ST_SENSE:  if (sigDetect)  nextState = ST_TIMING;
        ST_TIMING: if (timingDone) nextState = ST_SFD;
        ST_SFD:    if (sfdHit)     nextState = ST_DATA;
        ST_DATA:   if (rxDone)     nextState = ST_END;
        ST_END:    nextState = ST_END;
        default:   nextState = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.clrMatch = (state != ST_SFD);
    strb.shiftEn  = (state == ST_SFD) && rxEn && symValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      sfdFound <= 1'b0;
      dpClear  <= 1'b0;
    end else begin
      state    <= nextState;
      sfdFound <= (state == ST_SFD) && (nextState == ST_DATA);
      dpClear  <= (state != ST_IDLE) && (nextState == ST_IDLE);
    end
  end
endmodule

// File: rtl/bsrx_ctrl.sv
module bsrx_ctrl
  import bsrx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEn,
  input  logic       sigDetect,
  input  logic       timingDone,
  input  logic       rxDone,
  input  logic       lineCode,
  input  logic       symBit,
  input  logic       symValid,
  input  logic       symViol,
  output logic [2:0] stateCode,
  output logic       sfdFound,
  output logic       frameActive,
  output logic       dpClear
);
  timeunit 1ns;
  timeprecision 1ps;

  rxState_e   state;
  ctlStrobe_t strb;
  logic       sfdHit;

  bsrx_fsm u_fsm (
    .clk, .rstN, .rxEn, .sigDetect, .timingDone, .rxDone, .symValid,
    .sfdHit, .state, .strb, .sfdFound, .dpClear
  );

  bsrx_sfd_match u_match (
    .clk, .rstN, .strb, .lineCode, .symBit, .symViol, .sfdHit
  );

  assign stateCode   = state;
  assign frameActive = (state == ST_DATA);
endmodule

// File: rtl/bsrx_ctrl_chk.sv
module bsrx_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rxEn,
  input logic       sigDetect,
  input logic       timingDone,
  input logic       rxDone,
  input logic       lineCode,
  input logic       symBit,
  input logic       symValid,
  input logic       symViol,
  input logic [2:0] stateCode,
  input logic       sfdFound,
  input logic       frameActive,
  input logic       dpClear
);
  timeunit 1ns;
  timeprecision 1ps;

  AST_IDLE_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd0 && !rxEn) |=> stateCode == 3'd0);                 // R2
  AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode != $past(stateCode)) |->
      (stateCode == 3'd0 || stateCode == $past(stateCode) + 3'd1));     // R3
  AST_SFD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    sfdFound |=> !sfdFound);                                             // R4
  AST_SFD_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    sfdFound |-> (stateCode == 3'd4 && $past(stateCode) == 3'd3));       // R4
  AST_FRAME_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd4) |-> frameActive);                                // R8
  AST_END_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd5 && rxEn) |=> stateCode == 3'd5);                  // R9
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode != 3'd0 && !rxEn) |=> (stateCode == 3'd0 && dpClear));    // R10
  AST_CLEAR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    dpClear |=> !dpClear);                                               // R10
endmodule

bind bsrx_ctrl bsrx_ctrl_chk u_chk (.*);

// File: tb/sim_bsrx_ctrl.sv
module sim_bsrx_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxEn = 1'b0, sigDetect = 1'b0, timingDone = 1'b0, rxDone = 1'b0;
  logic lineCode = 1'b0, symBit = 1'b0, symValid = 1'b0, symViol = 1'b0;
  logic [2:0] stateCode;
  logic sfdFound, frameActive, dpClear;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [2:0] st;
    logic       sfd;
    logic       clr;
    string      tag;
  } item_t;

  item_t q[$];
  item_t it;

  always #2.5 clk = ~clk;

  bsrx_ctrl u0 (
    .clk, .rstN, .rxEn, .sigDetect, .timingDone, .rxDone, .lineCode,
    .symBit, .symValid, .symViol, .stateCode, .sfdFound, .frameActive, .dpClear
  );

  task automatic chk(input string tag, input logic [2:0] st, input logic sf,
                     input logic fa, input logic cl);
    total++;
    if (stateCode !== st || sfdFound !== sf || frameActive !== fa || dpClear !== cl) begin
      bad++;
      $display("FAIL %s: got state=%0d sfd=%0b act=%0b clr=%0b exp state=%0d sfd=%0b act=%0b clr=%0b",
               tag, stateCode, sfdFound, frameActive, dpClear, st, sf, fa, cl);
    end
  endtask

  // monitor: compare after each edge against the queued expectation
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      chk(it.tag, it.st, it.sfd, (it.st == 3'd4), it.clr);
    end
  end

  // driver: one cycle of stimulus plus its expected result
  task automatic cyc(input logic en, input logic sg, input logic tm, input logic dn,
                     input logic vl, input logic b, input logic vi,
                     input logic [2:0] es, input logic esf, input logic ec,
                     input string tag);
    item_t n;
    @(negedge clk);
    rxEn = en; sigDetect = sg; timingDone = tm; rxDone = dn;
    symValid = vl; symBit = b; symViol = vi;
    n.st = es; n.sfd = esf; n.clr = ec; n.tag = tag;
    q.push_back(n);
  endtask

  task automatic sym(input logic b, input logic vi, input logic [2:0] es,
                     input logic esf, input string tag);
    cyc(1, 0, 0, 0, 1, b, vi, es, esf, 0, tag);
  endtask

  task automatic toSfd(input string tag);
    cyc(1, 0, 0, 0, 0, 0, 0, 3'd1, 0, 0, tag);
    cyc(1, 1, 0, 0, 0, 0, 0, 3'd2, 0, 0, tag);
    cyc(1, 0, 1, 0, 0, 0, 0, 3'd3, 0, 0, tag);
  endtask

  task automatic abortTo(input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 3'd0, 0, 1, tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 3'd0, 0, 0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", 3'd0, 0, 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", 3'd0, 0, 0, 0);

    // R2 / R3 / R12 basic walk in FM0
    cyc(0, 1, 1, 1, 0, 0, 0, 3'd0, 0, 0, "R2 idle holds");
    cyc(1, 0, 0, 0, 0, 0, 0, 3'd1, 0, 0, "R2 idle to sensing");
    cyc(1, 0, 1, 1, 0, 0, 0, 3'd1, 0, 0, "R12 foreign strobes in sensing");
    cyc(1, 1, 0, 0, 0, 0, 0, 3'd2, 0, 0, "R3 sensing to timing");
    cyc(1, 1, 0, 1, 0, 0, 0, 3'd2, 0, 0, "R12 foreign strobes in timing");
    cyc(1, 0, 1, 0, 0, 0, 0, 3'd3, 0, 0, "R3 timing to search");
    // R4 FM0 frame with an invalid slot inside (R7)
    sym(1, 0, 3'd3, 0, "R4 fm0 s1");
    sym(0, 0, 3'd3, 0, "R4 fm0 s2");
    sym(1, 0, 3'd3, 0, "R4 fm0 s3");
    sym(0, 0, 3'd3, 0, "R4 fm0 s4");
    sym(0, 1, 3'd3, 0, "R4 fm0 viol");
    cyc(1, 0, 0, 0, 0, 0, 0, 3'd3, 0, 0, "R7 invalid symbol ignored");
    sym(1, 0, 3'd4, 1, "R4 fm0 match");
    cyc(1, 0, 0, 0, 0, 0, 0, 3'd4, 0, 0, "R4 sfd pulse single");
    cyc(1, 0, 0, 1, 0, 0, 0, 3'd5, 0, 0, "R8 payload to end");
    cyc(1, 1, 1, 1, 0, 0, 0, 3'd5, 0, 0, "R9 end hold strobes");
    cyc(1, 0, 0, 0, 1, 1, 0, 3'd5, 0, 0, "R9 end hold");
    cyc(1, 1, 0, 0, 0, 0, 0, 3'd5, 0, 0, "R9 end hold 2");
    abortTo("R10 abort from end");

    // R5 FM0 without violation
    toSfd("R5 setup");
    sym(1, 0, 3'd3, 0, "R5 s1");
    sym(0, 0, 3'd3, 0, "R5 s2");
    sym(1, 0, 3'd3, 0, "R5 s3");
    sym(0, 0, 3'd3, 0, "R5 s4");
    sym(0, 0, 3'd3, 0, "R5 no viol");
    sym(1, 0, 3'd3, 0, "R5 no match");
    abortTo("R10 abort from search");

    // R11 stale prefix must not survive an abort
    toSfd("R11 setup");
    sym(1, 0, 3'd3, 0, "R11 p1");
    sym(0, 0, 3'd3, 0, "R11 p2");
    sym(1, 0, 3'd3, 0, "R11 p3");
    sym(0, 0, 3'd3, 0, "R11 p4");
    sym(1, 1, 3'd3, 0, "R11 p5");
    abortTo("R11 abort");
    toSfd("R11 reenter");
    sym(1, 0, 3'd3, 0, "R11 stale no match");
    sym(1, 0, 3'd3, 0, "R4 again s1");
    sym(0, 0, 3'd3, 0, "R4 again s2");
    sym(1, 0, 3'd3, 0, "R4 again s3");
    sym(0, 0, 3'd3, 0, "R4 again s4");
    sym(1, 1, 3'd3, 0, "R4 again viol");
    sym(1, 0, 3'd4, 1, "R4 again match");
    cyc(0, 0, 0, 1, 0, 0, 0, 3'd0, 0, 1, "R12 abort beats done in payload");
    cyc(0, 0, 0, 0, 0, 0, 0, 3'd0, 0, 0, "R10 clear single");

    // aborts from sensing and timing, priority over advance strobes
    cyc(1, 0, 0, 0, 0, 0, 0, 3'd1, 0, 0, "R10 to sensing");
    cyc(0, 1, 0, 0, 0, 0, 0, 3'd0, 0, 1, "R12 abort beats detect");
    cyc(0, 0, 0, 0, 0, 0, 0, 3'd0, 0, 0, "R10 idle");
    cyc(1, 0, 0, 0, 0, 0, 0, 3'd1, 0, 0, "R10 to sensing 2");
    cyc(1, 1, 0, 0, 0, 0, 0, 3'd2, 0, 0, "R10 to timing");
    abortTo("R10 abort from timing");

    // R6 Miller with leading noise
    @(negedge clk);
    lineCode = 1'b1;
    toSfd("R6 setup");
    sym(1, 0, 3'd3, 0, "R6 noise1");
    sym(1, 0, 3'd3, 0, "R6 noise2");
    sym(0, 0, 3'd3, 0, "R6 m1");
    sym(1, 0, 3'd3, 0, "R6 m2");
    sym(0, 0, 3'd3, 0, "R6 m3");
    sym(1, 0, 3'd3, 0, "R6 m4");
    sym(1, 0, 3'd3, 0, "R6 m5");
    sym(1, 0, 3'd3, 0, "R6 m6");
    sym(1, 0, 3'd4, 1, "R6 miller match");
    cyc(1, 0, 0, 0, 0, 0, 0, 3'd4, 0, 0, "R8 payload stays");
    abortTo("R10 abort from payload");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got running exp finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule